// File: doc/BRIEF.md
# Oversampled SPI Mode-0 Target

This block is the target (slave) end of an SPI link that does not use the serial clock as a clock. The serial clock, the active-low select and the host-to-target data line are resynchronised into the system clock, and the block finds serial clock edges by comparing successive synchronised samples. Data is captured on rising edges and driven on falling edges, with clock polarity 0 and phase 0.

Each byte that arrives on the data input is presented on a parallel output with a one-cycle valid strobe. The byte to send back is offered through a valid/ready handshake. It is shifted out on the return line, MSB first, starting at the next select assertion or at the next byte boundary within a frame. The serial clock must stay well below the system clock; a ratio of one to ten or more is expected.

Top module: `spi_os_slave`

## Requirements
- R1: After synchronous active-high reset, `tx_ready_o` is 1, `rx_valid_o` is 0 and `miso_o` is 0.
- R2: While selected, `mosi_i` is sampled on each rising `sck_i` edge, MSB first. After every 8th rising edge the assembled byte appears on `rx_data_o`, with `rx_valid_o` high for exactly one system clock cycle.
- R3: A transmit byte is taken when `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` is 0 from the next cycle on. It returns to 1 once that byte's 8th falling `sck_i` edge has passed, or once the select deasserts while the byte is being shifted.
- R4: When `csn_i` falls, `miso_o` shows the MSB of a pending transmit byte within 4 system clock cycles. Each falling `sck_i` edge moves the next lower bit onto `miso_o`, and `miso_o` changes at no other time while selected.
- R5: A byte slot for which no transmit byte was pending sends 8 zero bits.
- R6: While `csn_i` is 1, `sck_i` toggles are ignored and the receive bit count is held at zero. A partial byte cut short by `csn_i` rising is discarded and never reported.
- R7: Within one select period the bit count wraps every 8 bits, so successive bytes are each reported. A transmit byte accepted during a frame is sent in the byte slot after the next byte boundary.
- R8: While `csn_i` is 1, `miso_o` is 0.
- R9: `tx_valid_i` while `tx_ready_o` is 0 has no effect: the pending byte is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| csn_i | input | 1 | Select, active low, asynchronous |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| tx_data_i | input | W | Byte to return to the host |
| tx_valid_i | input | 1 | Transmit byte is offered |
| tx_ready_o | output | 1 | Transmit byte can be taken |
| rx_data_o | output | W | Last byte received |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |

## Verification
The bench aborts frames after a few bits and toggles the serial clock while deselected. A design that does not clear its bit count would then report bytes that are shifted by the stray bits. It offers a second transmit byte while one is still pending, which catches a design that overwrites the pending byte. It runs frames of several bytes and loads a byte between two of them, which exposes wrong byte-boundary reloading: the reply would come one slot early or late, or a stale byte would be sent again instead of zeros. Random frames with a fixed seed mix preloaded and empty transmit slots, and the bench checks both directions bit for bit.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

  // Bit positions of the external lines inside the synchroniser bundle.
  localparam int LINE_SCK  = 0;
  localparam int LINE_CSN  = 1;
  localparam int LINE_MOSI = 2;
  localparam int LINE_CNT  = 3;

  // True when a bit counter sits on the final bit of a word.
  function automatic logic is_last(input int unsigned cnt, input int unsigned width);
    return cnt == width - 1;
  endfunction

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[i]}};
        else     chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic csn_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel_idle
);

  logic sck_q;
  logic csn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  assign sel_idle  = csn_s;
  assign sck_rise  = sck_s & ~sck_q & ~csn_s;
  assign sck_fall  = ~sck_s & sck_q & ~csn_s;
  assign sel_start = csn_q & ~csn_s;

endmodule

// File: rtl/spi_os_rx.sv
module spi_os_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_idle,
  input  logic         sck_rise,
  input  logic         mosi_s,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  import spi_os_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  shreg;
  logic [W-1:0]  next_word;

  assign next_word = {shreg[W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sel_idle) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg <= next_word;
        if (is_last(32'(bit_cnt), W)) begin
          bit_cnt  <= '0;
          rx_data  <= next_word;
          rx_valid <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_os_tx.sv
module spi_os_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_idle,
  input  logic         sel_start,
  input  logic         sck_fall,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         tx_load,
  output logic         miso
);
  import spi_os_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  hold;
  logic          busy;
  logic          owned;
  logic [W-1:0]  shreg;
  logic [CW-1:0] bit_cnt;
  logic          accept;
  logic          last_fall;

  assign accept    = tx_valid & ~busy;
  assign last_fall = sck_fall & is_last(32'(bit_cnt), W);
  assign tx_load   = sel_start | last_fall;
  assign tx_ready  = ~busy;
  assign miso      = shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      busy    <= 1'b0;
      owned   <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      if (sel_idle) begin
        shreg   <= '0;
        bit_cnt <= '0;
        if (owned) begin
          busy  <= 1'b0;
          owned <= 1'b0;
        end
      end else if (tx_load) begin
        bit_cnt <= '0;
        if (owned) begin
          busy  <= 1'b0;
          owned <= 1'b0;
          shreg <= '0;
        end else if (busy) begin
          shreg <= hold;
          owned <= 1'b1;
        end else begin
          shreg <= '0;
        end
      end else if (sck_fall) begin
        shreg   <= {shreg[W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (accept) begin
        hold <= tx_data;
        busy <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sck_i,
  input  logic         csn_i,
  input  logic         mosi_i,
  output logic         miso_o,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o
);
  import spi_os_pkg::*;

  localparam logic [LINE_CNT-1:0] IDLE_LEVELS = LINE_CNT'(1) << LINE_CSN;

  logic [LINE_CNT-1:0] raw_lines;
  logic [LINE_CNT-1:0] sync_lines;
  logic sck_rise;
  logic sck_fall;
  logic sel_start;
  logic cs_idle;
  logic tx_load;

  always_comb begin
    raw_lines            = '0;
    raw_lines[LINE_SCK]  = sck_i;
    raw_lines[LINE_CSN]  = csn_i;
    raw_lines[LINE_MOSI] = mosi_i;
  end

  spi_os_sync #(.LINES(LINE_CNT), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVELS)) u_sync (
    .clk(clk), .rst(rst), .d(raw_lines), .q(sync_lines)
  );

  spi_os_edge u_edge (
    .clk(clk), .rst(rst),
    .sck_s(sync_lines[LINE_SCK]), .csn_s(sync_lines[LINE_CSN]),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_start(sel_start), .sel_idle(cs_idle)
  );

  spi_os_rx #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .sel_idle(cs_idle), .sck_rise(sck_rise),
    .mosi_s(sync_lines[LINE_MOSI]), .rx_data(rx_data_o), .rx_valid(rx_valid_o)
  );

  spi_os_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .sel_idle(cs_idle), .sel_start(sel_start),
    .sck_fall(sck_fall), .tx_data(tx_data_i), .tx_valid(tx_valid_i),
    .tx_ready(tx_ready_o), .tx_load(tx_load), .miso(miso_o)
  );

endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_idle,
  input logic sck_fall,
  input logic tx_load,
  input logic miso_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o
);

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !rx_valid_o);

  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !miso_o);

  // R4
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_idle && !sck_fall && !tx_load) |=> $stable(miso_o));

endmodule

bind spi_os_slave spi_os_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_idle), .sck_fall(sck_fall),
  .tx_load(tx_load), .miso_o(miso_o), .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o)
);

// File: tb/sim_spi_os_slave.sv
module sim_spi_os_slave;

  localparam int CLK_P = 10;
  localparam int HALF  = 6;   // serial clock half period in system cycles

  logic       clk = 1'b0;
  logic       rst;
  logic       sck_i;
  logic       csn_i;
  logic       mosi_i;
  logic       miso_o;
  logic [7:0] tx_data_i;
  logic       tx_valid_i;
  logic       tx_ready_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] rx_log [0:255];
  int rx_n = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_os_slave #(.W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      rx_log[rx_n[7:0]] = rx_data_o;
      rx_n = rx_n + 1;
    end
  end

  function automatic logic [7:0] expect_reply(input bit loaded, input logic [7:0] val);
    return loaded ? val : 8'h00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input int n, input logic [7:0] mo, output logic [7:0] mi);
    mi = 8'h00;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      mosi_i = mo[7-b];
      wait_cyc(HALF);
      mi = {mi[6:0], miso_o};
      sck_i = 1'b1;
      wait_cyc(HALF);
      sck_i = 1'b0;
    end
    wait_cyc(HALF);
  endtask

  task automatic sel_on();
    @(negedge clk);
    csn_i = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic sel_off();
    wait_cyc(HALF);
    csn_i = 1'b1;
    wait_cyc(2*HALF);
  endtask

  task automatic load_tx(input logic [7:0] val, input string req);
    @(negedge clk);
    check(req, tx_ready_o, 1);
    tx_data_i  = val;
    tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    tx_data_i  = 8'h00;
    check("R3 ready low after load", tx_ready_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi, mi2, mi3;
    int base;
    void'($urandom(32'd2718));
    rst = 1'b1; sck_i = 1'b0; csn_i = 1'b1; mosi_i = 1'b0;
    tx_data_i = 8'h00; tx_valid_i = 1'b0;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    // R1 reset state
    check("R1 tx_ready", tx_ready_o, 1);
    check("R1 rx_valid", rx_valid_o, 0);
    check("R1 miso", miso_o, 0);

    // R2 R4 directed byte both ways
    load_tx(8'hA5, "R3 ready before load");
    base = rx_n;
    sel_on();
    xfer_bits(8, 8'h3C, mi);
    sel_off();
    check("R4 reply A5", mi, 8'hA5);
    check("R2 one byte", rx_n - base, 1);
    check("R2 rx 3C", rx_log[base[7:0]], 8'h3C);
    check("R3 ready after byte", tx_ready_o, 1);
    check("R8 miso idle", miso_o, 0);

    // R5 nothing loaded
    base = rx_n;
    sel_on();
    xfer_bits(8, 8'h81, mi);
    sel_off();
    check("R5 zero reply", mi, 8'h00);
    check("R2 rx 81", rx_log[base[7:0]], 8'h81);

    // R6 clock toggles while deselected, then aborted partial frame
    base = rx_n;
    xfer_bits(5, 8'hFF, mi);
    check("R6 no byte while deselected", rx_n - base, 0);
    load_tx(8'h77, "R3 ready before load");
    sel_on();
    xfer_bits(3, 8'hE0, mi);
    sel_off();
    check("R6 partial not reported", rx_n - base, 0);
    check("R4 partial bits", mi, 8'h03);
    check("R3 ready after abort", tx_ready_o, 1);
    load_tx(8'hC3, "R3 ready before load");
    sel_on();
    xfer_bits(8, 8'h5A, mi);
    sel_off();
    check("R6 clean byte after abort", rx_log[base[7:0]], 8'h5A);
    check("R6 one byte after abort", rx_n - base, 1);
    check("R4 reply C3", mi, 8'hC3);

    // R9 second offer while busy is ignored
    load_tx(8'h11, "R3 ready before load");
    @(negedge clk);
    tx_data_i = 8'hEE; tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    check("R9 still busy", tx_ready_o, 0);
    sel_on();
    xfer_bits(8, 8'h00, mi);
    sel_off();
    check("R9 kept first byte", mi, 8'h11);
    sel_on();
    xfer_bits(8, 8'h00, mi);
    sel_off();
    check("R9 second offer dropped", mi, 8'h00);

    // R7 three-byte frame with a load between bytes
    load_tx(8'h96, "R3 ready before load");
    base = rx_n;
    sel_on();
    xfer_bits(8, 8'h12, mi);
    load_tx(8'h4B, "R7 ready between bytes");
    xfer_bits(8, 8'h34, mi2);
    xfer_bits(8, 8'h56, mi3);
    sel_off();
    check("R7 slot1", mi, 8'h96);
    check("R7 slot2 empty", mi2, 8'h00);
    check("R7 slot3 late load", mi3, 8'h4B);
    check("R7 byte count", rx_n - base, 3);
    check("R7 rx1", rx_log[base[7:0]], 8'h12);
    check("R7 rx2", rx_log[8'(base+1)], 8'h34);
    check("R7 rx3", rx_log[8'(base+2)], 8'h56);

    // random frames
    for (int f = 0; f < 24; f++) begin
      int nb;
      bit pre;
      logic [7:0] val;
      nb  = 1 + int'($urandom % 3);
      pre = 1'($urandom);
      val = 8'($urandom);
      if (pre) load_tx(val, "R3 ready before load");
      base = rx_n;
      sel_on();
      for (int k = 0; k < nb; k++) begin
        logic [7:0] mo;
        mo = 8'($urandom);
        xfer_bits(8, mo, mi);
        check(k == 0 ? "R4 random reply" : "R5 random empty slot",
              mi, expect_reply(pre && k == 0, val));
        check("R2 random rx", rx_log[8'(base+k)], mo);
      end
      sel_off();
      check("R7 random count", rx_n - base, nb);
      check("R3 random ready", tx_ready_o, 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule